// File: doc/BRIEF.md
# Bus Transaction Trace Recorder

This block watches the transactions that pass from an upstream port to a device and keeps a compact 32-bit record for each one in an internal first-in first-out store. Each record carries the request-type bit, the read/write direction, the configuration-or-memory kind, and the transfer size. The size is held as a single set bit in the upper half-word. Addresses and data payloads are not captured. A burst is not folded into one record: every beat that arrives with the valid strobe becomes an entry of its own.

Software drains the store one entry at a time. The read data port always shows the oldest record that has not yet been read. A one-cycle pop strobe consumes that record. When nothing remains, the port shows all ones. A level enable decides whether beats are recorded. A clear pulse empties the store and drops the overflow flag. When the store is full, further beats are discarded and a sticky overflow flag is raised.

Top module: `trace_recorder`

## Requirements
- R1: Every entry has bit 0 equal to the beat's request-type input, bit 1 equal to 1 for a read and 0 for a write, and bit 2 equal to 1 for a configuration access and 0 for a memory access. Bits 15:3 are always zero.
- R2: The upper half-word of an entry (bits 31:16) has exactly one bit set. That bit is bit 16+n, where n is the 4-bit log2 of the beat's byte size; for example, an 8-byte beat (n=3) sets bit 19.
- R3: Each cycle in which the valid strobe is high while recording is enabled adds one entry. Entries are presented on the read data port oldest first, and each pop advances to the next entry.
- R4: When the store holds no entry, the read data port shows 0xFFFFFFFF. A pop while the store is empty has no effect.
- R5: The store holds DEPTH entries (64 by default). A beat that arrives while the store is full, with no pop in the same cycle, is dropped and leaves the stored entries unchanged. It also sets the overflow flag, which stays set until a clear.
- R6: While the enable input is low, beats are ignored and nothing is added to the store.
- R7: A clear pulse empties the store and resets the overflow flag in the next cycle. A beat in the same cycle as a clear is not recorded.
- R8: A beat and a pop in the same cycle are both honoured. This holds even when the store is full: the oldest entry is consumed, the new beat is stored as the newest entry, and overflow is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Recording enable level |
| clear | input | 1 | Pulse that empties the store and clears overflow |
| beat_valid | input | 1 | One transaction beat is present this cycle |
| beat_req | input | 1 | Request-type attribute (entry bit 0) |
| beat_read | input | 1 | 1 for read, 0 for write (entry bit 1) |
| beat_cfg | input | 1 | 1 for configuration, 0 for memory (entry bit 2) |
| beat_size_log2 | input | 4 | log2 of the beat's byte size |
| pop | input | 1 | Consume the entry shown on rd_data |
| rd_data | output | 32 | Oldest unread entry, or 0xFFFFFFFF when empty |
| overflow | output | 1 | Sticky flag: a beat was dropped because the store was full |

## Verification
Capture and readout can fall in the same cycle. The bench provokes this by raising a beat and a pop together, once with a single entry stored and once with the store full. It then drains the store and compares every entry against a record it builds from the beat attributes, and it expects overflow to stay clear. Clear is also raised together with a beat, and the bench expects the all-ones sentinel afterwards. Full sweeps over every size and attribute combination are also run, and each check tests field positions and order.

// File: rtl/trace_recorder.sv
module trace_recorder #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        clear,
  input  logic        beat_valid,
  input  logic        beat_req,
  input  logic        beat_read,
  input  logic        beat_cfg,
  input  logic [3:0]  beat_size_log2,
  input  logic        pop,
  output logic [31:0] rd_data,
  output logic        overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [31:0]      store [DEPTH];
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;

  wire is_empty = (count == '0);
  wire is_full  = (count == FULL_CNT);
  wire offered  = beat_valid & enable & ~clear;
  wire take_out = pop & ~is_empty & ~clear;
  wire take_in  = offered & (~is_full | take_out);
  wire refuse   = offered & is_full & ~take_out;

  wire [15:0] size_bit = 16'd1 << beat_size_log2;
  wire [31:0] record   = {size_bit, 13'd0, beat_cfg, beat_read, beat_req};

  assign rd_data = is_empty ? 32'hFFFF_FFFF : store[head];

  always_ff @(posedge clk)
    if (take_in) store[tail] <= record;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      head     <= '0;
      tail     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (take_in)  tail <= (tail == LAST_PTR) ? '0 : tail + 1'b1;
      if (take_out) head <= (head == LAST_PTR) ? '0 : head + 1'b1;
      if (take_in && !take_out)      count <= count + 1'b1;
      else if (take_out && !take_in) count <= count - 1'b1;
      if (refuse) overflow <= 1'b1;
    end
  end

  // R5
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R5
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear) |=> overflow);

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (rd_data == 32'hFFFF_FFFF && !overflow));

  // R6
  disabled_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clear) |=> (count <= $past(count)));

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && is_empty && !beat_valid) |=> (rd_data == 32'hFFFF_FFFF));

  // R8
  cap_pop_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && enable && !clear && pop && !is_empty) |=> ($stable(count) && !$rose(overflow)));
endmodule

// File: tb/trace_recorder_test.sv
module trace_recorder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, clear = 1'b0, beat_valid = 1'b0;
  logic        beat_req = 1'b0, beat_read = 1'b0, beat_cfg = 1'b0, pop = 1'b0;
  logic [3:0]  beat_size_log2 = '0;
  logic [31:0] rd_data;
  logic        overflow;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  trace_recorder #(.DEPTH(64)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
    .beat_valid(beat_valid), .beat_req(beat_req), .beat_read(beat_read),
    .beat_cfg(beat_cfg), .beat_size_log2(beat_size_log2), .pop(pop),
    .rd_data(rd_data), .overflow(overflow));

  // attribute code: [3:0] size log2, [4] req, [5] read, [6] cfg
  function automatic logic [31:0] expect_rec(input int code);
    logic [31:0] r;
    r = 32'd0;
    r[16 + (code & 15)] = 1'b1;
    r[0] = code[4];
    r[1] = code[5];
    r[2] = code[6];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input int code, input bit p, input bit en, input bit clr);
    @(negedge clk);
    beat_valid = v; pop = p; enable = en; clear = clr;
    beat_size_log2 = 4'(code & 15);
    beat_req = code[4]; beat_read = code[5]; beat_cfg = code[6];
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 1, 0);
  endtask

  task automatic sweep_round(input int base);
    for (int i = 0; i < 64; i++) cyc(1, base + i, 0, 1, 0);
    idle();
    chk("R5 no overflow at exactly full", {31'd0, overflow}, 32'd0);
    cyc(1, 127 - base, 0, 1, 0);
    idle();
    chk("R5 overflow set on beat while full", {31'd0, overflow}, 32'd1);
    for (int i = 0; i < 64; i++) begin
      chk("R1 R2 R3 entry fields and order", rd_data, expect_rec(base + i));
      cyc(0, 0, 1, 1, 0);
    end
    idle();
    chk("R4 sentinel after drain (R5 dropped beat absent)", rd_data, 32'hFFFF_FFFF);
    cyc(0, 0, 1, 1, 0);
    idle();
    chk("R4 pop on empty keeps sentinel", rd_data, 32'hFFFF_FFFF);
    chk("R5 overflow sticky", {31'd0, overflow}, 32'd1);
    cyc(0, 0, 0, 1, 1);
    idle();
    chk("R7 clear resets overflow", {31'd0, overflow}, 32'd0);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R4 reset sentinel", rd_data, 32'hFFFF_FFFF);
    chk("R5 reset overflow clear", {31'd0, overflow}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle();

    sweep_round(0);
    sweep_round(64);

    // R6 disabled beats are ignored
    cyc(1, 7, 0, 0, 0);
    cyc(1, 9, 0, 0, 0);
    idle();
    chk("R6 disabled beats not stored", rd_data, 32'hFFFF_FFFF);

    // R3 burst: back-to-back beats each become an entry
    cyc(1, 3, 0, 1, 0);
    cyc(1, 3, 0, 1, 0);
    cyc(1, 3, 0, 1, 0);
    idle();
    for (int i = 0; i < 3; i++) begin
      chk("R3 burst beat entry", rd_data, expect_rec(3));
      cyc(0, 0, 1, 1, 0);
    end
    idle();
    chk("R3 burst gives exactly three entries", rd_data, 32'hFFFF_FFFF);

    // R8 capture and pop in the same cycle, one stored entry
    cyc(1, 21, 0, 1, 0);
    cyc(1, 42, 1, 1, 0);
    idle();
    chk("R8 simultaneous: new head", rd_data, expect_rec(42));
    cyc(0, 0, 1, 1, 0);
    idle();
    chk("R8 simultaneous: one entry left", rd_data, 32'hFFFF_FFFF);

    // R8 capture and pop together while full
    for (int i = 0; i < 64; i++) cyc(1, i, 0, 1, 0);
    cyc(1, 100, 1, 1, 0);
    idle();
    chk("R8 full cap+pop no overflow", {31'd0, overflow}, 32'd0);
    for (int i = 1; i < 64; i++) begin
      chk("R8 full cap+pop order", rd_data, expect_rec(i));
      cyc(0, 0, 1, 1, 0);
    end
    chk("R8 full cap+pop newest entry", rd_data, expect_rec(100));
    cyc(0, 0, 1, 1, 0);
    idle();
    chk("R8 drained", rd_data, 32'hFFFF_FFFF);

    // R7 clear with a beat in the same cycle
    cyc(1, 5, 0, 1, 0);
    cyc(1, 6, 0, 1, 1);
    idle();
    chk("R7 clear wins over beat", rd_data, 32'hFFFF_FFFF);
    cyc(1, 77, 0, 1, 0);
    idle();
    chk("R7 capture resumes after clear", rd_data, expect_rec(77));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule